// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This block takes a 32-bit binary floating-point operand and rounds it to a whole number. The result stays in the same 32-bit floating-point format. The rounding direction comes from a 3-bit mode field. One mode value selects a separate dynamic-mode input instead, the way an instruction's static field can defer to a control register.

A single select bit picks between two variants. The plain variant only ever reports invalid operation. The exact variant also reports inexact whenever rounding moved the value.

The datapath is purely combinational. A parameter inserts one output register when timing needs it, and the register is reset synchronously.

Top module: `frti_unit`

## Requirements
- R1: Mode 0 (`rm_i`=3'd0) rounds to the nearest integer, and a value exactly halfway between two integers goes to the even one (2.5 gives 2.0, 3.5 gives 4.0, 1.5 gives 2.0, 0.5 gives +0.0). A carry out of the significand raises the exponent (8388607.5 gives 2^23).
- R2: Mode 1 truncates toward zero, mode 2 rounds toward minus infinity, mode 3 rounds toward plus infinity, and mode 4 rounds to nearest with halfway cases going away from zero.
- R3: A zero or infinite operand (exponent field all ones with zero fraction) is returned bit for bit unchanged, with neither flag set.
- R4: An operand whose biased exponent field is 150 or more (magnitude at least 2^23) and not 255 is returned unchanged with no flag.
- R5: Any NaN operand gives the canonical NaN 32'h7FC0_0000. A signalling NaN (fraction bit 22 clear, fraction nonzero) sets `invalid_o`. A quiet NaN (fraction bit 22 set) sets neither flag.
- R6: With `exact_i`=0, `inexact_o` is never set.
- R7: With `exact_i`=1, `inexact_o` is set exactly when the operand is neither NaN nor already integral and the result differs from it.
- R8: The result carries the sign of the operand. A negative operand that rounds to zero gives -0.0 (32'h8000_0000).
- R9: Subnormal operands round to a signed zero or to a signed 1.0 (32'h3F80_0000 with the operand's sign), as the active mode dictates.
- R10: Mode 7 takes the mode from `dyn_rm_i`, using the same encoding as modes 0 to 4.
- R11: A mode of 5 or 6, or mode 7 with `dyn_rm_i` equal to 5, 6 or 7, is reserved. It gives the canonical NaN with `invalid_o`=1 and `inexact_o`=0, for any operand.
- R12: With `REG_OUT`=1 the outputs appear one clock after the inputs and read zero during and just after reset. With `REG_OUT`=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only by the output register) |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Operand, single-precision |
| rm_i | input | 3 | Rounding mode; 7 defers to `dyn_rm_i` |
| dyn_rm_i | input | 3 | Dynamic rounding mode |
| exact_i | input | 1 | 1 selects the variant that reports inexact |
| res_o | output | 32 | Rounded value, single-precision |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The bench aims at the halfway cases under round-to-nearest-even. A design that rounded those away from zero would turn 2.5 into 3.0. It also exercises the carry from 8388607.5 and from 1.5. A unit that dropped that carry would return a value with the wrong exponent.

Several vectors have magnitude below one, including subnormals and -0.3. These catch a design that loses the sign and returns +0.0, or that ignores the directed modes and never produces ±1.0. Signalling and quiet NaNs, reserved and dynamic modes, and exactly integral inputs under the exact variant round out the stimulus. A wrong decode in any of these shows up as a wrong flag or a non-canonical NaN.

// File: rtl/frti_pkg.sv
package frti_pkg;

    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int FP_W     = 1 + EXP_W + MAN_W;
    localparam int SIG_W    = MAN_W + 1;
    localparam int SH_W     = $clog2(SIG_W);
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int INT_EXP  = BIAS + MAN_W;
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [FP_W-1:0]  CANON_NAN = {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4,
        RM_RSV5      = 3'd5,
        RM_RSV6      = 3'd6,
        RM_DYN       = 3'd7
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_BELOW_ONE,
        CL_MIXED,
        CL_INTEGRAL
    } cls_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef struct packed {
        logic [FP_W-1:0] val;
        logic            nv;
        logic            nx;
    } res_t;

    function automatic logic bump_needed(input rmode_e rm, input logic sign,
                                         input logic lsb, input logic rnd,
                                         input logic stk);
        logic r;
        case (rm)
            RM_NEAR_EVEN: r = rnd & (stk | lsb);
            RM_ZERO:      r = 1'b0;
            RM_DOWN:      r = sign & (rnd | stk);
            RM_UP:        r = ~sign & (rnd | stk);
            RM_NEAR_MAX:  r = rnd;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/frti_classify.sv
module frti_classify
    import frti_pkg::*;
(
    input  fp_t  op,
    output cls_e cls
);
    always_comb begin
        if (op.exp == EXP_ONES) begin
            if (op.man == '0)          cls = CL_INF;
            else if (op.man[MAN_W-1])  cls = CL_QNAN;
            else                       cls = CL_SNAN;
        end else if (op.exp == '0 && op.man == '0) begin
            cls = CL_ZERO;
        end else if (op.exp < EXP_W'(BIAS)) begin
            cls = CL_BELOW_ONE;
        end else if (op.exp >= EXP_W'(INT_EXP)) begin
            cls = CL_INTEGRAL;
        end else begin
            cls = CL_MIXED;
        end
    end
endmodule

// File: rtl/frti_mode_sel.sv
module frti_mode_sel
    import frti_pkg::*;
(
    input  logic [2:0] rm_i,
    input  logic [2:0] dyn_rm_i,
    output rmode_e     eff_rm,
    output logic       bad_rm
);
    logic [2:0] pick;

    always_comb begin
        pick   = (rm_i == 3'(RM_DYN)) ? dyn_rm_i : rm_i;
        eff_rm = rmode_e'(pick);
        bad_rm = (pick > 3'(RM_NEAR_MAX));
    end
endmodule

// File: rtl/frti_core.sv
module frti_core
    import frti_pkg::*;
(
    input  fp_t    op,
    input  cls_e   cls,
    input  rmode_e eff_rm,
    input  logic   bad_rm,
    input  logic   exact,
    output res_t   res
);
    logic [SIG_W-1:0] sig, mask, kept, shifted, shifted_m1;
    logic [SIG_W:0]   summed;
    logic [SH_W-1:0]  sh;
    logic [EXP_W-1:0] gap;
    logic             lsb, rnd, stk, inc;
    logic             tiny_rnd, tiny_stk, tiny_inc;

    always_comb begin
        sig        = {1'b1, op.man};
        gap        = EXP_W'(INT_EXP) - op.exp;
        sh         = gap[SH_W-1:0];
        mask       = (SIG_W'(1) << sh) - SIG_W'(1);
        shifted    = sig >> sh;
        shifted_m1 = sig >> (sh - SH_W'(1));
        lsb        = shifted[0];
        rnd        = shifted_m1[0];
        stk        = |(sig & (mask >> 1));
        inc        = bump_needed(eff_rm, op.sign, lsb, rnd, stk);
        kept       = sig & ~mask;
        summed     = {1'b0, kept} + (inc ? ((SIG_W+1)'(1) << sh) : '0);

        tiny_rnd   = (op.exp == EXP_W'(BIAS - 1));
        tiny_stk   = tiny_rnd ? (op.man != '0) : 1'b1;
        tiny_inc   = bump_needed(eff_rm, op.sign, 1'b0, tiny_rnd, tiny_stk);
    end

    always_comb begin
        res = '{val: op, nv: 1'b0, nx: 1'b0};
        if (bad_rm) begin
            res.val = CANON_NAN;
            res.nv  = 1'b1;
        end else begin
            unique case (cls)
                CL_QNAN: res.val = CANON_NAN;
                CL_SNAN: begin
                    res.val = CANON_NAN;
                    res.nv  = 1'b1;
                end
                CL_BELOW_ONE: begin
                    res.val = tiny_inc ? {op.sign, EXP_W'(BIAS), {MAN_W{1'b0}}}
                                       : {op.sign, {(FP_W-1){1'b0}}};
                    res.nx  = exact;
                end
                CL_MIXED: begin
                    if (summed[SIG_W])
                        res.val = {op.sign, op.exp + EXP_W'(1), summed[SIG_W-1:1]};
                    else
                        res.val = {op.sign, op.exp, summed[MAN_W-1:0]};
                    res.nx  = exact & (rnd | stk);
                end
                default: res.val = op;
            endcase
        end
    end
endmodule

// File: rtl/frti_out_stage.sv
module frti_out_stage
    import frti_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  res_t d,
    output res_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/frti_unit.sv
module frti_unit
    import frti_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] op_i,
    input  logic [2:0]  rm_i,
    input  logic [2:0]  dyn_rm_i,
    input  logic        exact_i,
    output logic [31:0] res_o,
    output logic        invalid_o,
    output logic        inexact_o
);
    fp_t    op;
    cls_e   cls;
    rmode_e eff_rm;
    logic   bad_rm;
    res_t   comb_res, out_res;

    assign op = fp_t'(op_i);

    frti_classify u_cls (.op(op), .cls(cls));

    frti_mode_sel u_mode (
        .rm_i     (rm_i),
        .dyn_rm_i (dyn_rm_i),
        .eff_rm   (eff_rm),
        .bad_rm   (bad_rm)
    );

    frti_core u_core (
        .op     (op),
        .cls    (cls),
        .eff_rm (eff_rm),
        .bad_rm (bad_rm),
        .exact  (exact_i),
        .res    (comb_res)
    );

    frti_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (comb_res),
        .q   (out_res)
    );

    assign res_o     = out_res.val;
    assign invalid_o = out_res.nv;
    assign inexact_o = out_res.nx;
endmodule

// File: rtl/frti_checker.sv
module frti_checker #(
    parameter bit LAT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] op_i,
    input logic [2:0]  rm_i,
    input logic [2:0]  dyn_rm_i,
    input logic        exact_i,
    input logic [31:0] res_o,
    input logic        invalid_o,
    input logic        inexact_o
);
    logic [31:0] op_c;
    logic [2:0]  rm_c, dyn_c;
    logic        exact_c, primed;

    generate
        if (LAT) begin : g_lat
            logic [31:0] op_q;
            logic [2:0]  rm_q, dyn_q;
            logic        exact_q, primed_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    op_q <= '0; rm_q <= '0; dyn_q <= '0;
                    exact_q <= 1'b0; primed_q <= 1'b0;
                end else begin
                    op_q <= op_i; rm_q <= rm_i; dyn_q <= dyn_rm_i;
                    exact_q <= exact_i; primed_q <= 1'b1;
                end
            end
            assign op_c = op_q; assign rm_c = rm_q; assign dyn_c = dyn_q;
            assign exact_c = exact_q; assign primed = primed_q;
        end else begin : g_now
            assign op_c = op_i; assign rm_c = rm_i; assign dyn_c = dyn_rm_i;
            assign exact_c = exact_i; assign primed = 1'b1;
        end
    endgenerate

    logic [2:0] mode_used;
    logic       mode_ok, in_nan, in_inf, in_zero, in_big;
    assign mode_used = (rm_c == 3'd7) ? dyn_c : rm_c;
    assign mode_ok   = (mode_used <= 3'd4);
    assign in_nan    = (op_c[30:23] == 8'hFF) && (op_c[22:0] != 0);
    assign in_inf    = (op_c[30:0] == 31'h7F80_0000);
    assign in_zero   = (op_c[30:0] == 31'd0);
    assign in_big    = (op_c[30:23] >= 8'd150) && (op_c[30:23] != 8'hFF);

    a_r3_inf_kept: assert property (@(posedge clk) disable iff (rst || !primed)
        (mode_ok && in_inf) |-> (res_o == op_c && !invalid_o && !inexact_o));
    a_r3_zero_kept: assert property (@(posedge clk) disable iff (rst || !primed)
        (mode_ok && in_zero) |-> (res_o == op_c && !invalid_o && !inexact_o));
    a_r4_large_kept: assert property (@(posedge clk) disable iff (rst || !primed)
        (mode_ok && in_big) |-> (res_o == op_c && !inexact_o));
    a_r5_invalid_canon: assert property (@(posedge clk) disable iff (rst || !primed)
        invalid_o |-> (res_o == 32'h7FC0_0000));
    a_r6_plain_no_inexact: assert property (@(posedge clk) disable iff (rst || !primed)
        !exact_c |-> !inexact_o);
    a_r7_inexact_changed: assert property (@(posedge clk) disable iff (rst || !primed)
        inexact_o |-> (res_o != op_c));
    a_r8_sign_kept: assert property (@(posedge clk) disable iff (rst || !primed)
        (mode_ok && !in_nan) |-> (res_o[31] == op_c[31]));
    a_r11_reserved: assert property (@(posedge clk) disable iff (rst || !primed)
        !mode_ok |-> (res_o == 32'h7FC0_0000 && invalid_o && !inexact_o));
endmodule

bind frti_unit frti_checker #(.LAT(REG_OUT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .rm_i      (rm_i),
    .dyn_rm_i  (dyn_rm_i),
    .exact_i   (exact_i),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
);

// File: tb/frti_unit_tb_top.sv
`timescale 1ns/1ps
module frti_unit_tb_top;

    typedef struct {
        logic [31:0] val;
        logic        nv;
        logic        nx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op = '0;
    logic [2:0]  rm = '0, dyn = '0;
    logic        exact = 1'b0;
    logic [31:0] res_r, res_c;
    logic        nv_r, nx_r, nv_c, nx_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sbq[$];
    exp_t prev;

    always #2 clk = ~clk;

    frti_unit #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .op_i(op), .rm_i(rm), .dyn_rm_i(dyn),
        .exact_i(exact), .res_o(res_r), .invalid_o(nv_r), .inexact_o(nx_r));

    frti_unit #(.REG_OUT(1'b0)) dut_comb_i (
        .clk(clk), .rst(rst), .op_i(op), .rm_i(rm), .dyn_rm_i(dyn),
        .exact_i(exact), .res_o(res_c), .invalid_o(nv_c), .inexact_o(nx_c));

    task automatic compare(input string what, input exp_t e,
                           input logic [31:0] v, input logic a, input logic b);
        checks++;
        if (v !== e.val || a !== e.nv || b !== e.nx) begin
            fails++;
            $display("FAIL %s %s: res=%h exp=%h nv=%b exp=%b nx=%b exp=%b",
                     e.tag, what, v, e.val, a, e.nv, b, e.nx);
        end
    endtask

    // one vector: chg = rounding moved the value (drives inexact in exact variant)
    task automatic apply(input logic [31:0] a, input logic [2:0] m, input logic [2:0] d,
                         input logic x, input logic [31:0] want, input logic nv,
                         input logic chg, input string tag);
        exp_t e;
        @(negedge clk);
        op = a; rm = m; dyn = d; exact = x;
        e.val = want; e.nv = nv; e.nx = x & chg; e.tag = tag;
        sbq.push_back(e);
        #1;
        compare("same-cycle REG_OUT=0", e, res_c, nv_c, nx_c);
        compare("R12 held until next edge", prev, res_r, nv_r, nx_r);
        prev = e;
        prev.tag = "R12";
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: pops one expected item per clock edge after its inputs were launched
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                compare("registered", e, res_r, nv_r, nx_r);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        prev.val = '0; prev.nv = 1'b0; prev.nx = 1'b0; prev.tag = "R12";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("reset state", prev, res_r, nv_r, nx_r); // R12
        rst = 1'b0;

        // R1 round to nearest, ties to even
        apply(32'h4020_0000, 3'd0, 3'd0, 1'b1, 32'h4000_0000, 1'b0, 1'b1, "R1");
        apply(32'h4060_0000, 3'd0, 3'd0, 1'b1, 32'h4080_0000, 1'b0, 1'b1, "R1");
        apply(32'h3FC0_0000, 3'd0, 3'd0, 1'b1, 32'h4000_0000, 1'b0, 1'b1, "R1");
        apply(32'h3F00_0000, 3'd0, 3'd0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, "R1");
        apply(32'h3F33_3333, 3'd0, 3'd0, 1'b1, 32'h3F80_0000, 1'b0, 1'b1, "R1");
        apply(32'h4AFF_FFFF, 3'd0, 3'd0, 1'b1, 32'h4B00_0000, 1'b0, 1'b1, "R1");
        // R2 directed and away-from-zero modes
        apply(32'h4020_0000, 3'd4, 3'd0, 1'b1, 32'h4040_0000, 1'b0, 1'b1, "R2");
        apply(32'h3F00_0000, 3'd4, 3'd0, 1'b1, 32'h3F80_0000, 1'b0, 1'b1, "R2");
        apply(32'hC020_0000, 3'd2, 3'd0, 1'b1, 32'hC040_0000, 1'b0, 1'b1, "R2");
        apply(32'hC020_0000, 3'd3, 3'd0, 1'b1, 32'hC000_0000, 1'b0, 1'b1, "R2");
        apply(32'hC020_0000, 3'd1, 3'd0, 1'b1, 32'hC000_0000, 1'b0, 1'b1, "R2");
        apply(32'h3FD9_999A, 3'd1, 3'd0, 1'b1, 32'h3F80_0000, 1'b0, 1'b1, "R2");
        apply(32'h3FD9_999A, 3'd3, 3'd0, 1'b1, 32'h4000_0000, 1'b0, 1'b1, "R2");
        // R3 zero and infinity unchanged
        apply(32'h8000_0000, 3'd3, 3'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, "R3");
        apply(32'hFF80_0000, 3'd0, 3'd0, 1'b1, 32'hFF80_0000, 1'b0, 1'b0, "R3");
        apply(32'h7F80_0000, 3'd2, 3'd0, 1'b1, 32'h7F80_0000, 1'b0, 1'b0, "R3");
        // R4 already integral
        apply(32'h4B00_0001, 3'd3, 3'd0, 1'b1, 32'h4B00_0001, 1'b0, 1'b0, "R4");
        apply(32'hCF00_1234, 3'd2, 3'd0, 1'b1, 32'hCF00_1234, 1'b0, 1'b0, "R4");
        // R5 NaNs
        apply(32'h7F80_0001, 3'd0, 3'd0, 1'b1, 32'h7FC0_0000, 1'b1, 1'b0, "R5");
        apply(32'hFFC0_0001, 3'd0, 3'd0, 1'b1, 32'h7FC0_0000, 1'b0, 1'b0, "R5");
        // R6 plain variant never reports inexact
        apply(32'h4020_0000, 3'd0, 3'd0, 1'b0, 32'h4000_0000, 1'b0, 1'b1, "R6");
        apply(32'hBE99_999A, 3'd2, 3'd0, 1'b0, 32'hBF80_0000, 1'b0, 1'b1, "R6");
        // R7 exact variant quiet when nothing moved
        apply(32'h4040_0000, 3'd0, 3'd0, 1'b1, 32'h4040_0000, 1'b0, 1'b0, "R7");
        // R8 sign kept on a zero result
        apply(32'hBE99_999A, 3'd0, 3'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b1, "R8");
        apply(32'hBF00_0000, 3'd3, 3'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b1, "R8");
        // R9 subnormals
        apply(32'h0000_0001, 3'd3, 3'd0, 1'b1, 32'h3F80_0000, 1'b0, 1'b1, "R9");
        apply(32'h0000_0001, 3'd1, 3'd0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, "R9");
        apply(32'h8000_0001, 3'd2, 3'd0, 1'b1, 32'hBF80_0000, 1'b0, 1'b1, "R9");
        // R10 dynamic mode
        apply(32'h3FA0_0000, 3'd7, 3'd3, 1'b1, 32'h4000_0000, 1'b0, 1'b1, "R10");
        apply(32'h3FA0_0000, 3'd7, 3'd1, 1'b1, 32'h3F80_0000, 1'b0, 1'b1, "R10");
        // R11 reserved modes
        apply(32'h3F80_0000, 3'd5, 3'd0, 1'b1, 32'h7FC0_0000, 1'b1, 1'b0, "R11");
        apply(32'hFF80_0000, 3'd6, 3'd0, 1'b1, 32'h7FC0_0000, 1'b1, 1'b0, "R11");
        apply(32'h4020_0000, 3'd7, 3'd7, 1'b1, 32'h7FC0_0000, 1'b1, 1'b0, "R11");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule